// File: doc/BRIEF.md
# Timer Tick Pending and Acknowledge Throttle

This block sits between the expiry strobes of a hardware tick timer and a processor interrupt line. Ticks that arrive while an earlier interrupt is still outstanding are not dropped. They accumulate in a saturating pending counter. The interrupt line carries at most one outstanding pulse at a time. A new pulse goes out only when three conditions hold: the consumer has asked for service, at least one tick is pending, and the previous pulse has been acknowledged. Each acknowledgement retires one pending tick. A burst of missed ticks is therefore replayed one interrupt at a time, at the pace the consumer can absorb.

Every reload of the timer's count latches a new counting mode. The mode decides which expiry strobes are counted. Periodic modes count every strobe. One-shot modes count only the first strobe after the reload. All other modes ignore strobes. A reload also empties the pending counter and re-arms the acknowledge flag, so a reprogrammed timer starts from a clean slate.

Top module: `tick_throttle`

## Requirements
- R1: After reset, `pend_cnt` is 0, `irq` is 0, the acknowledge flag is set, and the latched mode is 0, so expiries are ignored until the first reload.
- R2: In a periodic mode (mode code 2 or 3), each `expire` strobe with no `ack` and no `reload` raises `pend_cnt` by one, visible one cycle later.
- R3: `irq` goes high for exactly one cycle, one cycle after a cycle in which all of the following hold: `service` is high, `pend_cnt` is nonzero, the acknowledge flag is set, and neither `ack` nor `reload` is high. Issuing the pulse clears the flag, so later service requests produce no pulse until an `ack` arrives.
- R4: `ack` sets the acknowledge flag and lowers `pend_cnt` by one. At 0, the count stays at 0.
- R5: When a counted expiry and `ack` occur in the same cycle, `pend_cnt` is unchanged and the flag is set.
- R6: `pend_cnt` saturates at 255 (all ones of its 8 bits) and does not wrap on further expiries.
- R7: `reload` clears `pend_cnt`, sets the flag, latches `mode` and overrides `expire`, `ack` and `service` in that cycle.
- R8: In a one-shot mode (code 1 or 4), only the first `expire` after a reload is counted. Later strobes are ignored until the next reload.
- R9: In modes 0, 5, 6 and 7, `expire` strobes are ignored and `pend_cnt` does not change.
- R10: A `service` request in a cycle with `ack` high issues no pulse in that cycle.
- R11: `irq` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| expire | input | 1 | One-cycle timer expiry strobe |
| ack | input | 1 | One-cycle acknowledge of the last interrupt |
| reload | input | 1 | One-cycle strobe: count reloaded, latch `mode` |
| mode | input | 3 | Counting mode, sampled on `reload` |
| service | input | 1 | Consumer is ready to take an interrupt |
| irq | output | 1 | Single-cycle interrupt pulse |
| pend_cnt | output | 8 | Ticks not yet acknowledged |

## Verification
Periodic bursts with `service` held low build up a backlog. Releasing that backlog through service/acknowledge pairs shows that pulses are released one per acknowledge and never back to back. Coincident strobe pairs tell the priority rules apart: expire with ack, service with ack, and reload with everything else. A long run of expiries separates saturation from wrap-around. Replaying the same strobe train under each mode code shows that periodic, one-shot and stopped qualification each count a different number of strobes.

// File: rtl/thr_pkg.sv
package thr_pkg;

    localparam int MODE_W = 3;

    typedef logic [MODE_W-1:0] mode_t;

    // How a latched mode treats expiry strobes
    typedef enum logic [1:0] {
        CLS_STOP   = 2'd0,
        CLS_ONCE   = 2'd1,
        CLS_REPEAT = 2'd2
    } exp_class_e;

    localparam mode_t MODE_ONCE_A   = 3'd1;
    localparam mode_t MODE_REPEAT_A = 3'd2;
    localparam mode_t MODE_REPEAT_B = 3'd3;
    localparam mode_t MODE_ONCE_B   = 3'd4;

    function automatic exp_class_e classify(input mode_t m);
        exp_class_e c;
        case (m)
            MODE_REPEAT_A, MODE_REPEAT_B: c = CLS_REPEAT;
            MODE_ONCE_A,   MODE_ONCE_B:   c = CLS_ONCE;
            default:                      c = CLS_STOP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/thr_expiry_qual.sv
module thr_expiry_qual
    import thr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  expire_i,
    input  logic  reload_i,
    input  mode_t mode_i,
    output logic  count_o
);

    typedef struct packed {
        mode_t mode;
        logic  armed;
    } qual_st_t;

    qual_st_t   st_d, st_q;
    exp_class_e cls_q;

    assign cls_q = classify(st_q.mode);

    always_comb begin
        st_d    = st_q;
        count_o = 1'b0;
        if (reload_i) begin
            st_d.mode  = mode_i;
            st_d.armed = 1'b1;
        end else if (expire_i) begin
            case (cls_q)
                CLS_REPEAT: count_o = 1'b1;
                CLS_ONCE: begin
                    count_o    = st_q.armed;
                    st_d.armed = 1'b0;
                end
                default: count_o = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= '0;
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: a one-shot count is followed by no count until a reload
    a_r8_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o && cls_q == CLS_ONCE) |=> (!count_o || $past(reload_i) || classify(st_q.mode) != CLS_ONCE));

    // R9: stopped modes never count
    a_r9_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_q == CLS_STOP) |-> !count_o);

endmodule

// File: rtl/thr_pend_ctr.sv
module thr_pend_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (inc_i && !dec_i) begin
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end else if (dec_i && !inc_i) begin
            if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.cnt <= '0;
        else        st_q     <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R6: the count holds at its ceiling
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX && inc_i && !dec_i && !clr_i) |=> (cnt_o == CNT_MAX));

    // R4: the count holds at zero
    a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '0 && dec_i && !inc_i && !clr_i) |=> (cnt_o == '0));

    // R5: simultaneous up and down leave the count alone
    a_r5_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && dec_i && !clr_i) |=> $stable(cnt_o));

    // R7: a clear empties the counter
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/thr_issue_gate.sv
module thr_issue_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_nz_i,
    input  logic ack_i,
    input  logic reload_i,
    input  logic service_i,
    output logic irq_o
);

    typedef struct packed {
        logic acked;
        logic irq;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     fire;

    always_comb begin
        fire = service_i && pend_nz_i && st_q.acked && !ack_i && !reload_i;
        st_d = st_q;
        st_d.irq = fire;
        if (reload_i || ack_i) st_d.acked = 1'b1;
        else if (fire)         st_d.acked = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.acked <= 1'b1;
            st_q.irq   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    // R11: pulses are never adjacent
    a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R10: no pulse follows a cycle carrying an acknowledge
    a_r10_ack_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !irq_o);

    // R3: a pulse always answers a service request with work pending
    a_r3_requested: assert property (@(posedge clk) disable iff (!rst_n)
        (service_i && pend_nz_i && !ack_i && !reload_i && st_q.acked) |=> irq_o);

endmodule

// File: rtl/tick_throttle.sv
module tick_throttle
    import thr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expire,
    input  logic             ack,
    input  logic             reload,
    input  logic [2:0]       mode,
    input  logic             service,
    output logic             irq,
    output logic [CNT_W-1:0] pend_cnt
);

    logic counted;

    thr_expiry_qual u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire),
        .reload_i (reload),
        .mode_i   (mode),
        .count_o  (counted)
    );

    thr_pend_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (counted),
        .dec_i (ack),
        .clr_i (reload),
        .cnt_o (pend_cnt)
    );

    thr_issue_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_nz_i (pend_cnt != '0),
        .ack_i     (ack),
        .reload_i  (reload),
        .service_i (service),
        .irq_o     (irq)
    );

    // R3: a pulse only ever leaves with a nonzero backlog behind it
    a_r3_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(pend_cnt != '0 && service));

endmodule

// File: tb/tb_tick_throttle.sv
`timescale 1ns/1ps
module tb_tick_throttle;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       expire = 1'b0, ack = 1'b0, reload = 1'b0, service = 1'b0;
    logic [2:0] mode = 3'd0;
    logic       irq;
    logic [7:0] pend_cnt;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tick_throttle dut (
        .clk(clk), .rst_n(rst_n), .expire(expire), .ack(ack), .reload(reload),
        .mode(mode), .service(service), .irq(irq), .pend_cnt(pend_cnt)
    );

    typedef struct {
        bit       irq;
        int       pend;
        string    tag;
        bit       check;
    } exp_t;

    exp_t sb[$];

    // reference state
    int m_pend = 0;
    bit m_flag = 1;
    int m_mode = 0;
    bit m_armed = 0;

    task automatic step(input bit e, input bit a, input bit r, input bit s,
                        input int md, input string tag, input bit chk = 1);
        bit per, one, q, fire;
        exp_t x;
        @(negedge clk);
        expire = e; ack = a; reload = r; service = s; mode = md[2:0];
        per  = (m_mode == 2 || m_mode == 3);
        one  = (m_mode == 1 || m_mode == 4);
        q    = e && !r && (per || (one && m_armed));
        fire = s && m_pend != 0 && m_flag && !a && !r;
        if (r) begin
            m_pend = 0; m_flag = 1; m_mode = md; m_armed = 1;
        end else begin
            if (q && !a)      m_pend = (m_pend == 255) ? 255 : m_pend + 1;
            else if (a && !q) m_pend = (m_pend == 0) ? 0 : m_pend - 1;
            if (a)            m_flag = 1;
            else if (fire)    m_flag = 0;
            if (q)            m_armed = 0;
        end
        x.irq = fire; x.pend = m_pend; x.tag = tag; x.check = chk;
        sb.push_back(x);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, tag);
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            if (x.check) begin
                n_vec++;
                if (irq !== x.irq || int'(pend_cnt) != x.pend) begin
                    n_bad++;
                    $display("FAIL %s: irq=%0b pend=%0d expected irq=%0b pend=%0d",
                             x.tag, irq, pend_cnt, x.irq, x.pend);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        n_vec++;
        if (irq !== 1'b0 || pend_cnt !== 8'd0) begin
            n_bad++;
            $display("FAIL R1: irq=%0b pend=%0d expected irq=0 pend=0", irq, pend_cnt);
        end
        rst_n = 1'b1;
        // R1: mode 0 after reset ignores expiries
        step(1, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 1, 0, "R1");

        // R2: periodic mode 2, backlog of 3
        step(0, 0, 1, 0, 2, "R7");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R2");
        // R3: issue, then repeated service without ack issues nothing
        step(0, 0, 0, 1, 0, "R3");
        step(0, 0, 0, 1, 0, "R3");
        step(0, 0, 0, 1, 0, "R3");
        // R10: service together with ack gives no pulse
        step(0, 1, 0, 1, 0, "R10");
        step(0, 0, 0, 1, 0, "R11");
        step(0, 0, 0, 1, 0, "R11");
        // R5: expiry with ack
        step(1, 1, 0, 0, 0, "R5");
        step(0, 0, 0, 1, 0, "R3");
        // drain with ack, floor at zero (R4)
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, "R4");
        step(0, 0, 0, 1, 0, "R4");
        // R2: mode 3 also periodic
        step(0, 0, 1, 0, 3, "R7");
        step(1, 0, 0, 0, 0, "R2");
        step(1, 0, 0, 0, 0, "R2");
        // R7: reload overrides expire, ack and service
        step(1, 1, 1, 1, 2, "R7");
        step(0, 0, 0, 1, 0, "R7");

        // R6: saturation
        for (int i = 0; i < 260; i++) step(1, 0, 0, 0, 0, "R6");
        step(1, 0, 0, 0, 0, "R6");
        step(0, 1, 0, 0, 0, "R4");
        step(1, 0, 0, 0, 0, "R6");
        step(1, 0, 0, 0, 0, "R6");

        // R8: one-shot modes count only the first expiry
        step(0, 0, 1, 0, 1, "R7");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, "R8");
        step(0, 0, 1, 0, 4, "R7");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 1, 0, "R8");
        step(0, 1, 0, 0, 0, "R8");
        step(1, 0, 0, 0, 0, "R8");

        // R9: stopped modes
        for (int md = 5; md < 8; md++) begin
            step(0, 0, 1, 0, md, "R7");
            for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R9");
            step(0, 0, 0, 1, 0, "R9");
        end
        step(0, 0, 1, 0, 0, "R7");
        step(1, 0, 0, 0, 0, "R9");

        // R3/R11: backlog replay, service held high, ack every few cycles
        step(0, 0, 1, 0, 2, "R7");
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, "R2");
        for (int k = 0; k < 6; k++) begin
            step(0, 0, 0, 1, 0, "R11");
            step(0, 0, 0, 1, 0, "R11");
            step(0, 1, 0, 1, 0, "R10");
        end
        idle("R4");
        idle("R4");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule